// File: doc/BRIEF.md
# Accelerator Start/Done Control Register Block

This block is the small AXI4-Lite register set that sits in front of a compute core and lets software launch it and learn its state. Software sets a launch bit; the block holds a start request towards the core until the core takes it with its ready strobe. A completion from the core is caught in a sticky flag that software collects with a read. An optional re-launch mode starts the core again by itself after every completion.

Completions and launch acceptances can raise an interrupt. Each source has its own enable, and a captured source stays pending until software flips it off by writing a one to it. A master enable gates the single interrupt line. Idle and ready are shown live, as the core drives them.

Only the four control words at byte offsets 0x00, 0x04, 0x08 and 0x0C are decoded. Any other offset reads as zero and ignores writes.

Top module: `acc_ctrl_regs`

## Requirements
- R1: After reset `core_start` and `irq` are 0. The words at 0x04, 0x08 and 0x0C read 0. The word at 0x00 reads 0, apart from the live idle and ready bits.
- R2: A write with bit 0 set to offset 0x00 (byte lane 0 enabled) raises `core_start` on the clock edge that accepts the write. Writing 0 to bit 0 does not clear it. `core_start` stays high until the core accepts it.
- R3: `core_start` falls on the first edge at which it is high and `core_ready` is high. This does not happen if the same edge also re-launches the core or accepts a new launch write.
- R4: Bit 1 at 0x00 becomes 1 on the edge that samples `core_done` high. A read of 0x00 returns it and clears it, so the next read shows 0.
- R5: Bit 2 (idle) and bit 3 (ready) at 0x00 reflect `core_idle` and `core_ready` at the edge that accepts the read, without latching. Bits 4 to 6 and 8 upward read 0.
- R6: Bit 7 at 0x00 is a read/write re-launch flag. While it is 1, every edge that samples `core_done` high sets `core_start` again.
- R7: Bit 0 at 0x04 is the interrupt master enable. Bits 1:0 at 0x08 are the source enables, with bit 0 for completion and bit 1 for acceptance. All other bits of both words read 0.
- R8: Bits 1:0 at 0x0C are the pending flags, with bit 0 for completion and bit 1 for acceptance (`core_ready`). A pending flag is set by its event only while its source enable is 1.
- R9: Writing a 1 to a pending bit inverts it. Writing a 0 leaves it unchanged. A new event wins over a toggle in the same cycle.
- R10: `irq` is high exactly when the master enable is 1 and at least one pending flag is 1.
- R11: A write receives `bvalid` with OKAY response one cycle after acceptance. Read data arrives with `rvalid` one cycle after `arready`. Offsets beyond 0x0C read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Start request to the core |
| core_done | input | 1 | Core completion strobe |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core accepts start / ready strobe |
| irq | output | 1 | Interrupt request |

## Verification
The launch path is driven with a start write followed by an accept strobe, and then again with re-launch mode on. This separates a start that clears on acceptance from one that is re-armed by completion. Completion strobes are given with their source enable off and then on. This shows that capture depends on the enable, and back-to-back reads of the control word show the clear-on-read. Pending bits are written with ones and with zeros, starting from both the cleared and the set state, and the master enable is flipped while a flag is pending. Together these tell a toggle apart from a plain write or clear and confirm the output gating.

// File: rtl/acc_ctrl_pkg.sv
// Shared constants for the accelerator control register block.
// Assumes word-aligned AXI4-Lite accesses; the index is the byte offset / 4.
package acc_ctrl_pkg;
    localparam int IDX_CTRL = 0;   // 0x00 launch/status word
    localparam int IDX_GIE  = 1;   // 0x04 master interrupt enable
    localparam int IDX_IER  = 2;   // 0x08 source enables
    localparam int IDX_ISR  = 3;   // 0x0C pending flags

    localparam int BIT_START = 0;
    localparam int BIT_DONE  = 1;
    localparam int BIT_IDLE  = 2;
    localparam int BIT_READY = 3;
    localparam int BIT_AUTO  = 7;

    localparam int NUM_SRC  = 2;   // source 0: completion, source 1: acceptance
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/acc_axil_port.sv
// AXI4-Lite slave handshake front end.
// Accepts a write when address and data are both valid and no response is
// pending; accepts a read when no read data is pending. Emits one-cycle
// write/read fire strobes with word indices, and registers read data.
// Assumes the address and data of a write are presented together.
module acc_axil_port #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = ADDR_W - 2,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_fire,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_lane0,
    output logic              rd_fire,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_word
);
    logic accept_w;

    // Write accept: both channels present and response slot free.
    always_comb begin
        accept_w = awvalid && wvalid && !bvalid;
        awready  = accept_w;
        wready   = accept_w;
        wr_fire  = accept_w;
        wr_idx   = awaddr[ADDR_W-1:2];
        wr_data  = wdata;
        wr_lane0 = wstrb[0];
        arready  = !rvalid;
        rd_fire  = arvalid && !rvalid;
        rd_idx   = araddr[ADDR_W-1:2];
    end

    // Write response channel.
    always_ff @(posedge clk) begin
        if (!rst_n)          bvalid <= 1'b0;
        else if (accept_w)   bvalid <= 1'b1;
        else if (bready)     bvalid <= 1'b0;
    end

    // Read data channel: capture the selected word on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/acc_run_ctl.sv
// Launch and completion state for the core.
// Holds the start request until the core's ready strobe, latches completion
// until software reads the control word, and re-arms start after completion
// when re-launch is enabled. Assumes core_done/core_ready are clock-synchronous.
module acc_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_start,
    input  logic wr_auto,
    input  logic ctl_rd,
    input  logic core_done,
    input  logic core_ready,
    output logic start_o,
    output logic done_o,
    output logic auto_o
);
    logic start_set, start_clr;

    // Set/clear terms for the start request.
    always_comb begin
        start_set = (ctl_wr && wr_start) || (auto_o && core_done);
        start_clr = start_o && core_ready;
    end

    // Start request: set wins over acceptance clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          start_o <= 1'b0;
        else if (start_set)  start_o <= 1'b1;
        else if (start_clr)  start_o <= 1'b0;
    end

    // Sticky completion flag: a new completion wins over read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_o <= 1'b0;
        else if (core_done) done_o <= 1'b1;
        else if (ctl_rd)    done_o <= 1'b0;
    end

    // Re-launch mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      auto_o <= 1'b0;
        else if (ctl_wr) auto_o <= wr_auto;
    end
endmodule

// File: rtl/acc_irq_unit.sv
// Interrupt enables, pending flags and the interrupt output.
// Pending flags are set by enabled events and inverted by written ones;
// the output is the master enable gated with any pending flag.
module acc_irq_unit #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gie_wr,
    input  logic            ier_wr,
    input  logic            isr_wr,
    input  logic            wr_gie,
    input  logic [NSRC-1:0] wr_bits,
    input  logic [NSRC-1:0] events,
    output logic            gie_o,
    output logic [NSRC-1:0] ier_o,
    output logic [NSRC-1:0] isr_o,
    output logic            irq
);
    // Master enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_o <= 1'b0;
        else if (gie_wr) gie_o <= wr_gie;
    end

    // Source enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ier_o <= '0;
        else if (ier_wr) ier_o <= wr_bits;
    end

    // One pending flag per source.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // Enabled event sets; a written one toggles.
        always_ff @(posedge clk) begin
            if (!rst_n)                      isr_o[s] <= 1'b0;
            else if (events[s] && ier_o[s])  isr_o[s] <= 1'b1;
            else if (isr_wr && wr_bits[s])   isr_o[s] <= !isr_o[s];
        end
    end

    // Interrupt output.
    always_comb irq = gie_o && (|isr_o);
endmodule

// File: rtl/acc_ctrl_regs.sv
// Top of the accelerator start/done control register block.
// Decodes the four control words, routes side effects to the launch and
// interrupt units, and assembles read data. Assumes DATA_W >= 8 and ADDR_W >= 4.
module acc_ctrl_regs #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = ADDR_W - 2,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic              irq
);
    import acc_ctrl_pkg::*;

    logic              wr_fire, wr_lane0, rd_fire;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] wr_data, rd_word;
    logic              ctl_wr, gie_wr, ier_wr, isr_wr, ctl_rd;
    logic              done_w, auto_w, gie_w;
    logic [NUM_SRC-1:0] ier_w, isr_w, ev_w;

    acc_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
        .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_lane0(wr_lane0),
        .rd_fire(rd_fire), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    // Per-word write/read strobes; only byte lane 0 carries control bits.
    always_comb begin
        ctl_wr  = wr_fire && wr_lane0 && (wr_idx == IDX_W'(IDX_CTRL));
        gie_wr  = wr_fire && wr_lane0 && (wr_idx == IDX_W'(IDX_GIE));
        ier_wr  = wr_fire && wr_lane0 && (wr_idx == IDX_W'(IDX_IER));
        isr_wr  = wr_fire && wr_lane0 && (wr_idx == IDX_W'(IDX_ISR));
        ctl_rd  = rd_fire && (rd_idx == IDX_W'(IDX_CTRL));
        ev_w    = {core_ready, core_done};
        s_bresp = RESP_OKAY;
        s_rresp = RESP_OKAY;
    end

    acc_run_ctl u_run (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .wr_start(wr_data[BIT_START]), .wr_auto(wr_data[BIT_AUTO]),
        .ctl_rd(ctl_rd), .core_done(core_done), .core_ready(core_ready),
        .start_o(core_start), .done_o(done_w), .auto_o(auto_w)
    );

    acc_irq_unit #(.NSRC(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .gie_wr(gie_wr), .ier_wr(ier_wr), .isr_wr(isr_wr),
        .wr_gie(wr_data[0]), .wr_bits(wr_data[NUM_SRC-1:0]), .events(ev_w),
        .gie_o(gie_w), .ier_o(ier_w), .isr_o(isr_w), .irq(irq)
    );

    // Read data selection; idle and ready are shown live.
    always_comb begin
        rd_word = '0;
        case (rd_idx)
            IDX_W'(IDX_CTRL): begin
                rd_word[BIT_START] = core_start;
                rd_word[BIT_DONE]  = done_w;
                rd_word[BIT_IDLE]  = core_idle;
                rd_word[BIT_READY] = core_ready;
                rd_word[BIT_AUTO]  = auto_w;
            end
            IDX_W'(IDX_GIE): rd_word[0] = gie_w;
            IDX_W'(IDX_IER): rd_word[NUM_SRC-1:0] = ier_w;
            IDX_W'(IDX_ISR): rd_word[NUM_SRC-1:0] = isr_w;
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/acc_ctrl_regs_chk.sv
// Temporal checks for acc_ctrl_regs, attached by bind below.
module acc_ctrl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_start,
    input logic       core_ready,
    input logic       core_done,
    input logic       awvalid,
    input logic       awready,
    input logic       bvalid,
    input logic       bready,
    input logic       arvalid,
    input logic       arready,
    input logic       rvalid,
    input logic       irq,
    input logic [1:0] isr,
    input logic       auto_on,
    input logic       done_flag
);
    // R2
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start && !core_ready |=> core_start);
    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start && core_ready && !core_done && !(awvalid && awready) |=> !core_start);
    // R4
    done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_flag);
    // R6
    relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done && auto_on |=> core_start);
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr == 2'b00 |-> !irq);
    // R11
    bresp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && awready |=> bvalid);
    // R11
    bhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R11
    rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> rvalid);
endmodule

bind acc_ctrl_regs acc_ctrl_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_ready(core_ready),
    .core_done(core_done), .awvalid(s_awvalid), .awready(s_awready),
    .bvalid(s_bvalid), .bready(s_bready), .arvalid(s_arvalid), .arready(s_arready),
    .rvalid(s_rvalid), .irq(irq), .isr(isr_w), .auto_on(auto_w), .done_flag(done_w)
);

// File: tb/tb_acc_ctrl_regs.sv
module tb_acc_ctrl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [3:0] wstrb = 4'hF;
    logic bready = 1'b1, rready = 1'b1;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DATA_W-1:0] rdata;
    logic core_done = 1'b0, core_idle = 1'b1, core_ready = 1'b0;
    logic core_start, irq;

    int n_total = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
        .core_ready(core_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as the design returns it.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 1, 0);
            end else begin
                automatic logic [DATA_W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    // Driver: write one word, check the response one cycle later (R11).
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        check("R11 bvalid/bresp", {bvalid, bresp}, {1'b1, 2'b00});
        @(negedge clk);
    endtask

    // Driver: read one word, pushing the expectation to the scoreboard.
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                      input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        araddr = a; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk); core_ready = 1'b1;
        @(negedge clk); core_ready = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 core_start", core_start, 0);
        check("R1 irq", irq, 0);
        rd(6'h00, 32'h4, "R1 ctrl");
        rd(6'h04, 32'h0, "R1 gie");
        rd(6'h08, 32'h0, "R1 ier");
        rd(6'h0C, 32'h0, "R1 isr");
        // R5 live idle/ready
        @(negedge clk); core_idle = 1'b0; core_ready = 1'b1;
        rd(6'h00, 32'h8, "R5 live ready, idle low");
        core_ready = 1'b0; core_idle = 1'b1;
        rd(6'h00, 32'h4, "R5 live idle");
        // R2 launch
        wr(6'h00, 32'h1);
        check("R2 start raised", core_start, 1);
        repeat (3) @(negedge clk);
        check("R2 start held", core_start, 1);
        rd(6'h00, 32'h5, "R2 ctrl start bit");
        // R3 accept clears start
        pulse_ready();
        check("R3 start cleared", core_start, 0);
        // R4 sticky done, clear on read
        pulse_done();
        rd(6'h00, 32'h6, "R4 done latched");
        rd(6'h00, 32'h4, "R4 done cleared by read");
        // R7 enable words, R11 unmapped
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, 32'h1, "R7 gie");
        wr(6'h08, 32'h0000_00FF);
        rd(6'h08, 32'h3, "R7 ier");
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, 32'h0, "R11 unmapped");
        // R8 enable-gated capture
        wr(6'h08, 32'h0);
        pulse_done();
        rd(6'h0C, 32'h0, "R8 done masked");
        rd(6'h00, 32'h6, "R4 done latched again");
        wr(6'h08, 32'h1);
        pulse_ready();
        rd(6'h0C, 32'h0, "R8 ready masked");
        pulse_done();
        rd(6'h0C, 32'h1, "R8 done captured");
        check("R10 irq on", irq, 1);
        // R9 toggle on write
        wr(6'h0C, 32'h1);
        rd(6'h0C, 32'h0, "R9 toggle off");
        check("R10 irq off", irq, 0);
        wr(6'h0C, 32'h0);
        rd(6'h0C, 32'h0, "R9 zero write no effect");
        wr(6'h0C, 32'h2);
        rd(6'h0C, 32'h2, "R9 toggle on");
        check("R10 irq from bit1", irq, 1);
        wr(6'h04, 32'h0);
        check("R10 irq gated by master", irq, 0);
        wr(6'h0C, 32'h2);
        rd(6'h0C, 32'h0, "R9 toggle bit1 off");
        // R6 re-launch
        rd(6'h00, 32'h6, "R4 clear pending done");
        wr(6'h00, 32'h80);
        rd(6'h00, 32'h84, "R6 auto bit");
        wr(6'h00, 32'h81);
        pulse_ready();
        check("R3 start cleared in auto", core_start, 0);
        pulse_done();
        check("R6 re-launched", core_start, 1);
        rd(6'h00, 32'h87, "R6 ctrl after re-launch");
        wr(6'h00, 32'h0);
        rd(6'h00, 32'h5, "R2 zero write keeps start");
        pulse_ready();
        pulse_done();
        check("R6 no re-launch when off", core_start, 0);
        repeat (3) @(negedge clk);
        check("R11 queue drained", exp_q.size(), 0);
        summary();
    end
endmodule